// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers 32 level-sensitive second-level interrupt sources and folds them onto 12 first-level request lines. The sources are grouped in four 8-bit groups. Each group has a fixed inactive level per bit, so a source counts as active when its synchronised raw bit differs from that level. Sources reach the first-level lines through a fixed, irregular many-to-one routing. Some sources reach no line at all.

Two masking layers gate the result. One mask bit sits in front of each source, and one sits in front of each first-level line. A byte-wide register port lets software read the synchronised raw status and read and write both mask layers. A combinational vector lookup takes a first-level line index and returns the number of the lowest active, enabled source behind that line. The design has no edge latching and no acknowledge: every output follows the input levels.

Top module: `irq_aggr_top`

## Requirements
- R1: After synchronous reset, every mask bit reads as 1 (disabled), `line_irq` is all zero and `reg_rdata` is zero.
- R2: A source is active when its raw bit differs from its group's inactive pattern. The patterns are 0x00 for group 0, 0xBE for group 1, 0xFC for group 2 and 0xF7 for group 3. Source n is group n/8, bit n%8.
- R3: Second-level mask bit n set to 1 disables source n, and set to 0 enables it.
- R4: Line k is high when at least one source routed to k is active and enabled. The route for sources 0..27 is 7,7,7,7,7,7,7,7, 4,6,6,6,6,6,8,9, 11,11,5,5,5,5,0,1, 3,10,10,2. Sources 28..31 reach no line.
- R5: First-level mask bit k set to 1 forces line k low. Line k sits at address 8, bit k for k<8, and at address 9, bit k-8 otherwise.
- R6: A register read returns data on `reg_rdata` one clock after the address is presented. Addresses 0..3 read the synchronised raw bits of groups 0..3. Addresses 4..7 read and write the second-level masks of groups 0..3. Address 9 bits 7:4 read 0.
- R7: Writes to addresses 0..3 and to addresses 10..15 change no state. Addresses 10..15 read 0.
- R8: For a line index below 12, `vec_valid` is high when some source routed to that line is active and enabled at the second level. `vec_num` then gives the lowest such source number, group*8+bit. The first-level mask does not affect the lookup.
- R9: For a line index of 12..15, `vec_valid` is low.
- R10: A raw input change reaches the vector lookup after 2 clock edges and `line_irq` after 3. A mask write reaches `line_irq` one edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_raw | input | 32 | Raw second-level source levels, asynchronous |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| line_irq | output | 12 | Registered first-level request lines |
| vec_line | input | 4 | Line index for the vector lookup |
| vec_valid | output | 1 | A qualifying source exists behind `vec_line` |
| vec_num | output | 5 | Lowest qualifying source number |

## Verification
Each result has its own latency. A raw change passes two synchroniser flops, so the vector lookup sees it two edges later, and the registered line output shows it one edge after that. A mask write takes effect on the line output on the next edge, and read data appears one edge after the address. The bench drives every input on a falling edge and samples on a later falling edge. A directed case checks the exact edge of each latency. The random rounds wait at least four edges after their last change before they compare against the model.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int GRP_W      = 8;
  localparam int NUM_GRP    = 4;
  localparam int NUM_SRC    = GRP_W * NUM_GRP;
  localparam int NUM_LINES  = 12;
  localparam int LINE_IDX_W = $clog2(NUM_LINES + 1);
  localparam int SRC_IDX_W  = $clog2(NUM_SRC);
  localparam int GSEL_W     = $clog2(NUM_GRP);
  localparam int BSEL_W     = $clog2(GRP_W);
  localparam int ADDR_W     = 4;

  // level each status bit rests at when its source is idle
  function automatic logic [GRP_W-1:0] idle_level(input int g);
    case (g)
      1:       return 8'hBE;
      2:       return 8'hFC;
      3:       return 8'hF7;
      default: return 8'h00;
    endcase
  endfunction

  // status group feeding each first-level line
  function automatic logic [GSEL_W-1:0] line_group(input int k);
    case (k)
      0, 1, 5, 11: return 2'd2;
      2, 3, 10:    return 2'd3;
      4, 6, 8, 9:  return 2'd1;
      default:     return 2'd0;
    endcase
  endfunction

  // bits of that group routed to the line
  function automatic logic [GRP_W-1:0] line_sel(input int k);
    case (k)
      0, 8:    return 8'h40;
      1, 9:    return 8'h80;
      2:       return 8'h08;
      3, 4:    return 8'h01;
      5:       return 8'h3C;
      6:       return 8'h3E;
      7:       return 8'hFF;
      10:      return 8'h06;
      11:      return 8'h03;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_aggr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic [GRP_W-1:0]     wdata,
  input  logic [NUM_SRC-1:0]   stat,
  output logic [NUM_SRC-1:0]   l2_mask,
  output logic [NUM_LINES-1:0] l1_mask,
  output logic [GRP_W-1:0]     rdata
);
  localparam int L1_HI_W = NUM_LINES - GRP_W;

  logic [GRP_W-1:0] rd_nxt;
  logic [1:0]       gsel;

  assign gsel = addr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      l2_mask <= '1;
      l1_mask <= '1;
    end else if (wr) begin
      if (addr[3:2] == 2'b01)
        l2_mask[gsel*GRP_W +: GRP_W] <= wdata;
      else if (addr == 4'd8)
        l1_mask[GRP_W-1:0] <= wdata;
      else if (addr == 4'd9)
        l1_mask[NUM_LINES-1:GRP_W] <= wdata[L1_HI_W-1:0];
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (addr[3:2])
      2'b00: rd_nxt = stat[gsel*GRP_W +: GRP_W];
      2'b01: rd_nxt = l2_mask[gsel*GRP_W +: GRP_W];
      2'b10: begin
        if (gsel == 2'd0) rd_nxt = l1_mask[GRP_W-1:0];
        else if (gsel == 2'd1) rd_nxt = {{(GRP_W-L1_HI_W){1'b0}}, l1_mask[NUM_LINES-1:GRP_W]};
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_aggr_pkg::*;
(
  input  logic [NUM_SRC-1:0]    act,
  input  logic [NUM_SRC-1:0]    l2_mask,
  input  logic [NUM_LINES-1:0]  l1_mask,
  input  logic [LINE_IDX_W-1:0] vec_line,
  output logic [NUM_LINES-1:0]  line_nxt,
  output logic                  vec_valid,
  output logic [SRC_IDX_W-1:0]  vec_num
);
  logic [NUM_SRC-1:0] qual;
  assign qual = act & ~l2_mask;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    localparam int          GRP = int'(line_group(k));
    localparam logic [7:0]  SEL = line_sel(k);
    assign line_nxt[k] = (|(qual[GRP*GRP_W +: GRP_W] & SEL)) & ~l1_mask[k];
  end

  always_comb begin
    logic [GSEL_W-1:0] g;
    logic [GRP_W-1:0]  hits;
    vec_valid = 1'b0;
    vec_num   = '0;
    g         = '0;
    hits      = '0;
    if (int'(vec_line) < NUM_LINES) begin
      g    = line_group(int'(vec_line));
      hits = qual[g*GRP_W +: GRP_W] & line_sel(int'(vec_line));
      for (int i = GRP_W - 1; i >= 0; i--) begin
        if (hits[i]) begin
          vec_valid = 1'b1;
          vec_num   = {g, BSEL_W'(i)};
        end
      end
    end
  end
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
  import irq_aggr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    src_raw,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic [GRP_W-1:0]      reg_wdata,
  output logic [GRP_W-1:0]      reg_rdata,
  output logic [NUM_LINES-1:0]  line_irq,
  input  logic [LINE_IDX_W-1:0] vec_line,
  output logic                  vec_valid,
  output logic [SRC_IDX_W-1:0]  vec_num
);
  logic [NUM_SRC-1:0]   stat_sync;
  logic [NUM_SRC-1:0]   idle_vec;
  logic [NUM_SRC-1:0]   act;
  logic [NUM_SRC-1:0]   l2_mask;
  logic [NUM_LINES-1:0] l1_mask;
  logic [NUM_LINES-1:0] line_nxt;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_idle
    assign idle_vec[g*GRP_W +: GRP_W] = idle_level(g);
  end

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk (clk), .rst (rst), .d (src_raw), .q (stat_sync)
  );

  assign act = stat_sync ^ idle_vec;

  irq_regs u_regs (
    .clk (clk), .rst (rst), .addr (reg_addr), .wr (reg_wr),
    .wdata (reg_wdata), .stat (stat_sync), .l2_mask (l2_mask),
    .l1_mask (l1_mask), .rdata (reg_rdata)
  );

  irq_route u_route (
    .act (act), .l2_mask (l2_mask), .l1_mask (l1_mask),
    .vec_line (vec_line), .line_nxt (line_nxt),
    .vec_valid (vec_valid), .vec_num (vec_num)
  );

  always_ff @(posedge clk) begin
    if (rst) line_irq <= '0;
    else     line_irq <= line_nxt;
  end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
  import irq_aggr_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic                  reg_wr,
  input logic [NUM_LINES-1:0]  line_irq,
  input logic [LINE_IDX_W-1:0] vec_line,
  input logic                  vec_valid,
  input logic [SRC_IDX_W-1:0]  vec_num,
  input logic [NUM_SRC-1:0]    act,
  input logic [NUM_SRC-1:0]    l2_mask,
  input logic [NUM_LINES-1:0]  l1_mask
);
  p_lines_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> line_irq == '0);

  p_l1_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (line_irq & $past(l1_mask)) == '0);

  p_vec_qualified_r8: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (act[vec_num] && !l2_mask[vec_num]));

  p_vec_group_r8: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> vec_num[SRC_IDX_W-1:BSEL_W] == line_group(int'(vec_line)));

  p_vec_range_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(vec_line) >= NUM_LINES) |-> !vec_valid);

  p_status_ro_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr[3:2] == 2'b00) |=> ($stable(l2_mask) && $stable(l1_mask)));
endmodule

bind irq_aggr_top irq_aggr_chk u_chk (
  .clk (clk), .rst (rst), .reg_addr (reg_addr), .reg_wr (reg_wr),
  .line_irq (line_irq), .vec_line (vec_line), .vec_valid (vec_valid),
  .vec_num (vec_num), .act (act), .l2_mask (l2_mask), .l1_mask (l1_mask)
);

// File: tb/irq_aggr_top_tb.sv
module irq_aggr_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_raw = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [11:0] line_irq;
  logic [3:0]  vec_line = '0;
  logic        vec_valid;
  logic [4:0]  vec_num;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_l2 = '1;
  logic [11:0] m_l1 = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggr_top u_dut (
    .clk (clk), .rst (rst), .src_raw (src_raw), .reg_addr (reg_addr),
    .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .line_irq (line_irq), .vec_line (vec_line), .vec_valid (vec_valid),
    .vec_num (vec_num)
  );

  function automatic int route(input int n);
    int t[28] = '{7,7,7,7,7,7,7,7, 4,6,6,6,6,6,8,9, 11,11,5,5,5,5,0,1, 3,10,10,2};
    if (n >= 28) return -1;
    return t[n];
  endfunction

  function automatic logic [31:0] idle32();
    return {8'hF7, 8'hFC, 8'hBE, 8'h00};
  endfunction

  function automatic logic [11:0] exp_lines(input logic [31:0] raw,
                                            input logic [31:0] l2, input logic [11:0] l1);
    logic [11:0] r = '0;
    logic [31:0] a = (raw ^ idle32()) & ~l2;
    for (int n = 0; n < 32; n++)
      if (a[n] && route(n) >= 0) r[route(n)] = 1'b1;
    return r & ~l1;
  endfunction

  function automatic int exp_vec(input int line, input logic [31:0] raw, input logic [31:0] l2);
    logic [31:0] a = (raw ^ idle32()) & ~l2;
    for (int n = 0; n < 32; n++)
      if (a[n] && route(n) == line) return n;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a >= 4 && a <= 7) m_l2[(a-4)*8 +: 8] = d;
    else if (a == 8) m_l1[7:0] = d;
    else if (a == 9) m_l1[11:8] = d[3:0];
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_vec(input int line, input string req);
    int e;
    vec_line = 4'(line);
    #1;
    e = (line < 12) ? exp_vec(line, src_raw, m_l2) : -1;
    if (e < 0) check(vec_valid == 1'b0, req, int'(vec_valid), 0);
    else check(vec_valid && int'(vec_num) == e, req, vec_valid ? int'(vec_num) : -1, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(line_irq == 12'h0, "R1 lines", int'(line_irq), 0);
    check(reg_rdata == 8'h00, "R1 rdata", int'(reg_rdata), 0);
    for (int a = 4; a <= 8; a++) begin
      rd(a, d); check(d == 8'hFF, "R1 mask reset", int'(d), 8'hFF);
    end
    rd(9, d); check(d == 8'h0F, "R1 R6 l1 high", int'(d), 8'h0F);

    // R2 status readback is raw, not normalised
    src_raw = 32'hA5C3_3C5A;
    settle();
    rd(1, d); check(d == 8'h3C, "R2 R6 status read", int'(d), 8'h3C);
    rd(3, d); check(d == 8'hA5, "R6 status read", int'(d), 8'hA5);

    // everything idle, all enabled
    src_raw = idle32();
    for (int a = 4; a <= 9; a++) wr(a, 8'h00);
    settle();
    check(line_irq == 12'h0, "R2 idle levels give no line", int'(line_irq), 0);

    // R10 latency: source 0 active (group 0 idle 0)
    vec_line = 4'd7;
    @(negedge clk);
    src_raw[0] = 1'b1;
    @(negedge clk);
    check(vec_valid == 1'b0, "R10 vec after 1 edge", int'(vec_valid), 0);
    @(negedge clk);
    check(vec_valid && vec_num == 5'd0, "R10 vec after 2 edges", int'(vec_valid), 1);
    check(line_irq[7] == 1'b0, "R10 line after 2 edges", int'(line_irq[7]), 0);
    @(negedge clk);
    check(line_irq[7] == 1'b1, "R10 line after 3 edges", int'(line_irq[7]), 1);

    // R7 status write ignored
    wr(0, 8'h55);
    rd(4, d); check(d == 8'h00, "R7 status write", int'(d), 0);
    rd(0, d); check(d == 8'h01, "R7 status unchanged", int'(d), 1);
    check(line_irq == 12'h080, "R7 lines unchanged", int'(line_irq), 12'h080);
    wr(10, 8'hFF);
    rd(10, d); check(d == 8'h00, "R7 unused addr", int'(d), 0);
    check(line_irq == 12'h080, "R7 unused write", int'(line_irq), 12'h080);

    // R8 lowest wins, R3 mask disables
    src_raw[7:0] = 8'hFF;
    settle();
    check_vec(7, "R8 lowest bit");
    check(vec_num == 5'd0, "R8 vec 0", int'(vec_num), 0);
    wr(4, 8'h01);
    check_vec(7, "R3 R8 masked bit skipped");
    check(vec_num == 5'd1, "R3 vec 1", int'(vec_num), 1);

    // R5 first-level mask; mask write latency R10
    wr(8, 8'h80);
    check(line_irq[7] == 1'b1, "R10 mask write before edge", int'(line_irq[7]), 1);
    @(negedge clk);
    check(line_irq[7] == 1'b0, "R5 line masked", int'(line_irq[7]), 0);
    check_vec(7, "R8 vec ignores l1 mask");

    // R9 out-of-range indexes with everything active
    src_raw = ~idle32();
    wr(4, 8'h00); wr(8, 8'h00);
    settle();
    for (int k = 12; k < 16; k++) check_vec(k, "R9 range");
    check(line_irq == exp_lines(src_raw, m_l2, m_l1), "R4 all active",
          int'(line_irq), int'(exp_lines(src_raw, m_l2, m_l1)));

    // R4 source 28..31 reach nothing
    src_raw = idle32();
    src_raw[31:28] = ~src_raw[31:28];
    settle();
    check(line_irq == 12'h0, "R4 unrouted sources", int'(line_irq), 0);

    // random rounds
    for (int it = 0; it < 300; it++) begin
      src_raw = $urandom();
      if (it % 3 == 0)
        for (int a = 4; a <= 9; a++) wr(a, 8'($urandom() & $urandom()));
      settle();
      check(line_irq == exp_lines(src_raw, m_l2, m_l1), "R4 R5 random lines",
            int'(line_irq), int'(exp_lines(src_raw, m_l2, m_l1)));
      for (int k = 0; k < 16; k++) check_vec(k, "R8 R9 random vec");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule